// File: doc/BRIEF.md
# Frame Status Flag Serializer

Once per audio frame, this block takes a snapshot of eight one-bit decoder status flags and sends them out one after another on a single status pin. The frame strobe arrives at 7.35×n kHz, where n is the disc speed. The first flag in the word does not come from the flag vector. It is built from a subcode-sync pulse that has already passed through the frame FIFO, so its position in time matches the audio samples leaving the converter path. The other seven flags carry the second-stage corrector's uncorrectable-symbol status, which concealment uses.

Each bit takes the same number of system clocks, set by a parameter. The word is sent first flag first. When all eight bits have gone out, the pin returns low and waits for the next strobe.

The block can also embed flags in the digital audio output. When embedding is enabled, the bit handed to the audio formatter for the least significant bit of the 24-bit sample word is taken from the latched flag word instead of from the audio data. A select input chooses which flag is used.

Top module: `frame_flag_serializer`

## Requirements
- R1: From reset until the first frame strobe after reset, `flagPin` stays low.
- R2: A frame strobe latches the word {F1, `flagVec[6:0]`}, with F1 in bit 7. Starting on the cycle after the strobe, `flagPin` presents bits 7 down to 0 in turn, each for `SLOT_CYCLES` clock cycles.
- R3: Once the eighth bit has been presented, `flagPin` stays low until the next frame strobe.
- R4: Changing `flagVec` or `syncPulse` after the strobe does not change the word being shifted out or the latched word.
- R5: F1 is 1 exactly when `syncPulse` was high on at least one clock between the previous strobe (that strobe excluded) and the current strobe (included).
- R6: A strobe that arrives while a word is still being shifted drops that word and immediately starts the new one, beginning at bit 7.
- R7: While `embedEn` is 1, `lsbOut` equals bit (7 − `flagSel`) of the latched word. So `flagSel` = 0 selects F1.
- R8: While `embedEn` is 0, `lsbOut` equals `audioLsb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStb | input | 1 | One-cycle pulse at the start of each frame |
| syncPulse | input | 1 | Subcode sync, already delayed through the FIFO |
| flagVec | input | 7 | Second-stage status flags F2..F8 (bit 6 = F2) |
| embedEn | input | 1 | Enables embedding a flag in the audio LSB |
| flagSel | input | 3 | Selects which latched flag is embedded |
| audioLsb | input | 1 | Original LSB of the 24-bit audio word |
| flagPin | output | 1 | Serial flag output |
| lsbOut | output | 1 | LSB passed to the digital audio formatter |

## Verification
The hardest situation to reach from the ports is a strobe that lands partway through a word. It must cut the old word off cleanly and restart at bit 7, and the sync pulse must land on exactly the strobe cycle so that it counts toward the new F1. The stimulus produces this with frames shorter than eight slots. It also places sync pulses on the strobe cycle, in the middle of a frame and on the last cycle of a frame, and inverts `flagVec` in the middle of a frame. A behavioural model counts the cycles since the last strobe and predicts both outputs on every clock.

// File: rtl/flag_ser_pkg.sv
package flag_ser_pkg;
  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic load;    // frame strobe accepted: latch a new word
    logic shift;   // advance to the next bit
    logic active;  // a word is being presented on the pin
  } flagCtrlT;
endpackage

// File: rtl/flag_ser_ctrl.sv
module flag_ser_ctrl
  import flag_ser_pkg::*;
#(
  parameter int FLAG_W      = 8,
  parameter int SLOT_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStb,
  output flagCtrlT ctrl
);
  localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam int BIT_W  = (FLAG_W > 1) ? $clog2(FLAG_W) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FLAG_W - 1);

  logic [SLOT_W-1:0] slotCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              active;
  logic              slotEnd;

  assign slotEnd     = active && (slotCnt == SLOT_LAST) && !frameStb;
  assign ctrl.load   = frameStb;
  assign ctrl.shift  = slotEnd;
  assign ctrl.active = active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotCnt <= '0;
      bitCnt  <= '0;
    end else if (frameStb) begin
      active  <= 1'b1;
      slotCnt <= '0;
      bitCnt  <= '0;
    end else if (slotEnd) begin
      slotCnt <= '0;
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == BIT_LAST) active <= 1'b0;
    end else if (active) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |=> (active && slotCnt == '0 && bitCnt == '0));

  // R3
  word_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotEnd && bitCnt == BIT_LAST) |=> !active);
endmodule

// File: rtl/flag_ser_datapath.sv
module flag_ser_datapath
  import flag_ser_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCtrlT          ctrl,
  input  logic              syncPulse,
  input  logic [FLAG_W-2:0] flagVec,
  input  logic              embedEn,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic              audioLsb,
  output logic              flagPin,
  output logic              lsbOut
);
  logic [FLAG_W-1:0] shiftReg;
  logic [FLAG_W-1:0] wordReg;
  logic              syncSeen;
  logic              syncFlag;
  logic [FLAG_W-1:0] newWord;

  assign syncFlag = syncSeen | syncPulse;
  assign newWord  = {syncFlag, flagVec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wordReg  <= '0;
      syncSeen <= 1'b0;
    end else begin
      if (ctrl.load) begin
        shiftReg <= newWord;
        wordReg  <= newWord;
        syncSeen <= 1'b0;
      end else begin
        if (syncPulse)  syncSeen <= 1'b1;
        if (ctrl.shift) shiftReg <= {shiftReg[FLAG_W-2:0], 1'b0};
      end
    end
  end

  assign flagPin = ctrl.active & shiftReg[FLAG_W-1];
  assign lsbOut  = embedEn ? wordReg[FLAG_W-1-int'(flagSel)] : audioLsb;

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(wordReg));

  // R5
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncPulse && !ctrl.load) |=> syncSeen);
endmodule

// File: rtl/frame_flag_serializer.sv
module frame_flag_serializer
  import flag_ser_pkg::*;
#(
  parameter int FLAG_W      = 8,
  parameter int SLOT_CYCLES = 4,
  localparam int SEL_W      = $clog2(FLAG_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic              syncPulse,
  input  logic [FLAG_W-2:0] flagVec,
  input  logic              embedEn,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic              audioLsb,
  output logic              flagPin,
  output logic              lsbOut
);
  flagCtrlT ctrl;

  flag_ser_ctrl #(.FLAG_W(FLAG_W), .SLOT_CYCLES(SLOT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .ctrl(ctrl)
  );

  flag_ser_datapath #(.FLAG_W(FLAG_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .syncPulse(syncPulse),
    .flagVec(flagVec), .embedEn(embedEn), .flagSel(flagSel),
    .audioLsb(audioLsb), .flagPin(flagPin), .lsbOut(lsbOut)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rstN) && !$past(frameStb)) |-> !flagPin);
endmodule

// File: tb/frame_flag_serializer_bench.sv
module frame_flag_serializer_bench;
  localparam int S = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStb = 1'b0;
  logic       syncPulse = 1'b0;
  logic [6:0] flagVec = '0;
  logic       embedEn = 1'b0;
  logic [2:0] flagSel = '0;
  logic       audioLsb = 1'b0;
  logic       flagPin;
  logic       lsbOut;

  int vectors = 0;
  int misses = 0;
  string phaseTag = "R2";

  // Reference model state
  bit       started = 0;
  bit       syncM = 0;
  int       elapsed = 0;
  bit [7:0] wordM = '0;

  always #5 clk = ~clk;

  frame_flag_serializer #(.FLAG_W(8), .SLOT_CYCLES(S)) u_frame_flag_serializer (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .syncPulse(syncPulse),
    .flagVec(flagVec), .embedEn(embedEn), .flagSel(flagSel),
    .audioLsb(audioLsb), .flagPin(flagPin), .lsbOut(lsbOut)
  );

  task automatic compare(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic expPin, expLsb;
    string pinTag;
    @(posedge clk);
    if (!rstN) begin
      started = 0; syncM = 0; elapsed = 0; wordM = '0;
    end else if (frameStb) begin
      wordM = {syncM | syncPulse, flagVec};
      syncM = 0; elapsed = 0; started = 1;
    end else begin
      if (syncPulse) syncM = 1;
      elapsed++;
    end
    #2;
    if (!started) begin
      expPin = 1'b0; pinTag = "R1";
    end else if (elapsed < 8 * S) begin
      expPin = wordM[7 - elapsed / S]; pinTag = phaseTag;
    end else begin
      expPin = 1'b0; pinTag = "R3";
    end
    compare(pinTag, flagPin, expPin);
    expLsb = embedEn ? wordM[7 - int'(flagSel)] : audioLsb;
    compare(embedEn ? "R7" : "R8", lsbOut, expLsb);
  endtask

  // One frame of len cycles; sync on cycle syncAt (-1 = none); optional flip of flagVec mid-frame
  task automatic frame(int len, logic [6:0] vec, int syncAt, bit flip);
    frameStb = 1'b1; flagVec = vec; syncPulse = (syncAt == 0);
    tick();
    frameStb = 1'b0;
    for (int i = 1; i < len; i++) begin
      syncPulse = (i == syncAt);
      if (flip && i == 3) flagVec = ~vec;
      flagSel = 3'(i % 8);
      audioLsb = i[1];
      tick();
    end
  endtask

  initial begin
    #200000;
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: reset and idle before any strobe
    for (int i = 0; i < 3; i++) tick();
    rstN = 1'b1;
    syncPulse = 1'b1; tick(); syncPulse = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    // R2, R3, R5: full frames with idle gap, sync before first strobe counts
    phaseTag = "R2";
    frame(40, 7'b1010011, -1, 0);
    phaseTag = "R5";
    frame(40, 7'b0000000, 0, 0);
    frame(40, 7'b1111111, 17, 0);
    frame(40, 7'b0101100, 39, 0);
    // R4: flag vector flips mid-frame
    phaseTag = "R4";
    frame(40, 7'b1100101, -1, 1);
    // R7: embedding with a sweep of flagSel
    embedEn = 1'b1;
    phaseTag = "R2";
    frame(40, 7'b0110110, 5, 0);
    frame(36, 7'b1001001, -1, 1);
    // R6: strobes arriving mid-word
    phaseTag = "R6";
    frame(13, 7'b1111000, 12, 0);
    frame(6, 7'b0001111, -1, 0);
    frame(1, 7'b1010101, -1, 0);
    embedEn = 1'b0;
    frame(20, 7'b0110011, 0, 0);
    phaseTag = "R3";
    frame(45, 7'b1000001, -1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule